// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the two privileged return operations of a RISC-V hart: the machine-level return and the supervisor-level return. A single-cycle request strobe presents the current privilege level, the virtualization flag, the machine and hypervisor status words, the two exception PCs and a flag that says the protection unit has no rules programmed. One cycle later the unit returns a result. The result is either a fault cause or the complete post-return state: the updated status words, the privilege and virtualization flag to resume in, the return PC, and a request to swap the hypervisor register banks.

The unit never stalls. There is no ready signal, so a request is accepted in the cycle its strobe is high. Strobes may arrive back to back, and each strobe produces exactly one response beat one cycle later. Optional features are set by parameters: the hypervisor extension, U mode, compressed instructions, the protection unit and the 1.12 privileged rules. When a return faults, the result echoes the inputs unchanged. The core can then commit or discard the result without further muxing.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return gives cause 1 (illegal) when the current privilege is U (encoding 0), or when mstatus bit 22 (trap-sret) is set and the privilege is not M (encoding 3).
- R2: A supervisor return with the virtualization flag set and hstatus bit 22 (virtual trap-sret) set gives cause 2 (virtual instruction), unless R1 already applies.
- R3: A machine return from any privilege other than M gives cause 1.
- R4: Without compressed support, a return target whose low two bits are not both zero gives cause 3 (misaligned), unless R1, R2 or R3 applies. The target is mepc for a machine return and sepc for a supervisor return.
- R5: A machine return with the protection unit present, its no-rules flag high and mstatus bits 12:11 (previous machine privilege) not equal to 3 gives cause 4 (access fault), with the lowest priority.
- R6: A successful supervisor return resumes at privilege {0, mstatus bit 8}. It copies bit 5 into bit 1, then sets bit 5 and clears bit 8.
- R7: A successful machine return resumes at the privilege in bits 12:11. It copies bit 7 into bit 3, sets bit 7, and writes bits 12:11 to 0 when U mode exists (3 otherwise). It also clears bit 39.
- R8: Under the 1.12 rules, mstatus bit 17 (modify-privilege) is cleared by every successful supervisor return. A machine return clears it only when bits 12:11 were not 3.
- R9: With the hypervisor extension, a successful supervisor return made outside virtual mode takes its new virtualization flag from hstatus bit 7 and clears that bit. A successful machine return takes its new flag from mstatus bit 39. Otherwise the flag is kept.
- R10: The bank swap request is high exactly when R9 restored a virtualization flag of 1.
- R11: rsp_valid is high in the cycle after each req_valid cycle and low otherwise. ret_pc is the selected exception PC. On any fault, the status outputs, privilege and flag equal the inputs, and the swap request is low.
- R12: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization flag |
| mstatus_in | input | 64 | Machine status word |
| hstatus_in | input | 64 | Hypervisor status word |
| mepc_in | input | XLEN | Machine exception PC |
| sepc_in | input | XLEN | Supervisor exception PC |
| pmp_no_rules | input | 1 | Protection unit has no rules programmed |
| rsp_valid | output | 1 | Result beat |
| rsp_cause | output | 3 | 0 none, 1 illegal, 2 virtual instruction, 3 misaligned, 4 access fault |
| mstatus_out | output | 64 | Updated machine status |
| hstatus_out | output | 64 | Updated hypervisor status |
| new_priv | output | 2 | Privilege to resume in |
| new_virt | output | 1 | Virtualization flag to resume with |
| ret_pc | output | XLEN | Return target |
| swap_banks | output | 1 | Request hypervisor register bank swap |

## Verification
The bench builds the unit with XLEN 32, the hypervisor extension, U mode, the protection unit and the 1.12 rules all enabled, and compressed support disabled. Disabling compressed support makes the misaligned cause reachable, so its priority against the illegal, virtual-instruction and access-fault causes can be exercised. Enabling the hypervisor extension brings the SPV and MPV restore paths and the swap request into play. Enabling the 1.12 rules covers the conditional clearing of the modify-privilege bit.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_ILLEGAL  = 3'd1,
    CAUSE_VIRT     = 3'd2,
    CAUSE_MISALIGN = 3'd3,
    CAUSE_ACCESS   = 3'd4
  } ret_cause_e;

  // mstatus field positions, decoded by the rest of the hart
  localparam int MS_SIE    = 1;
  localparam int MS_MIE    = 3;
  localparam int MS_SPIE   = 5;
  localparam int MS_MPIE   = 7;
  localparam int MS_SPP    = 8;
  localparam int MS_MPP_LO = 11;
  localparam int MS_MPP_HI = 12;
  localparam int MS_MPRV   = 17;
  localparam int MS_TSR    = 22;
  localparam int MS_MPV    = 39;
  // hstatus field positions
  localparam int HS_SPV    = 7;
  localparam int HS_VTSR   = 22;
  localparam int SW        = 64;
endpackage

// File: rtl/trap_ret_check.sv
module trap_ret_check
  import trap_ret_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit HAS_C   = 1'b0,
  parameter bit HAS_PMP = 1'b1
) (
  input  logic            is_mret,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic            tsr,
  input  logic            vtsr,
  input  logic [1:0]      prev_mpp,
  input  logic [1:0]      epc_low,
  input  logic            pmp_no_rules,
  output ret_cause_e      cause
);
  logic illegal, virt_fault, misalign, access;

  always_comb begin
    if (is_mret) begin
      illegal    = (cur_priv != PRIV_M);
      virt_fault = 1'b0;
    end else begin
      illegal    = (cur_priv < PRIV_S) || (tsr && cur_priv != PRIV_M);
      virt_fault = cur_virt && vtsr;
    end
  end

  generate
    if (HAS_C) begin : g_compressed
      assign misalign = 1'b0;
    end else begin : g_word_only
      assign misalign = |epc_low;
    end
    if (HAS_PMP) begin : g_pmp
      assign access = is_mret && pmp_no_rules && (prev_mpp != PRIV_M);
    end else begin : g_no_pmp
      assign access = 1'b0;
    end
  endgenerate

  always_comb begin
    if (illegal)         cause = CAUSE_ILLEGAL;
    else if (virt_fault) cause = CAUSE_VIRT;
    else if (misalign)   cause = CAUSE_MISALIGN;
    else if (access)     cause = CAUSE_ACCESS;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/trap_ret_update.sv
module trap_ret_update
  import trap_ret_pkg::*;
#(
  parameter bit HAS_H     = 1'b1,
  parameter bit HAS_U     = 1'b1,
  parameter bit SPEC_1_12 = 1'b1
) (
  input  logic          is_mret,
  input  logic          cur_virt,
  input  logic [SW-1:0] mst,
  input  logic [SW-1:0] hst,
  output logic [SW-1:0] mst_nxt,
  output logic [SW-1:0] hst_nxt,
  output logic [1:0]    priv_nxt,
  output logic          virt_nxt,
  output logic          swap
);
  localparam logic [1:0] MPP_RESET = HAS_U ? PRIV_U : PRIV_M;

  always_comb begin
    mst_nxt  = mst;
    hst_nxt  = hst;
    virt_nxt = cur_virt;
    swap     = 1'b0;
    if (is_mret) begin
      priv_nxt                     = mst[MS_MPP_HI:MS_MPP_LO];
      mst_nxt[MS_MIE]              = mst[MS_MPIE];
      mst_nxt[MS_MPIE]             = 1'b1;
      mst_nxt[MS_MPP_HI:MS_MPP_LO] = MPP_RESET;
      mst_nxt[MS_MPV]              = 1'b0;
      if (SPEC_1_12 && mst[MS_MPP_HI:MS_MPP_LO] != PRIV_M)
        mst_nxt[MS_MPRV] = 1'b0;
      if (HAS_H) begin
        virt_nxt = mst[MS_MPV];
        swap     = mst[MS_MPV];
      end
    end else begin
      priv_nxt          = {1'b0, mst[MS_SPP]};
      mst_nxt[MS_SIE]   = mst[MS_SPIE];
      mst_nxt[MS_SPIE]  = 1'b1;
      mst_nxt[MS_SPP]   = 1'b0;
      if (SPEC_1_12)
        mst_nxt[MS_MPRV] = 1'b0;
      if (HAS_H && !cur_virt) begin
        virt_nxt        = hst[HS_SPV];
        hst_nxt[HS_SPV] = 1'b0;
        swap            = hst[HS_SPV];
      end
    end
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_ret_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_H     = 1'b1,
  parameter bit HAS_U     = 1'b1,
  parameter bit HAS_C     = 1'b0,
  parameter bit HAS_PMP   = 1'b1,
  parameter bit SPEC_1_12 = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_is_mret,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic [63:0]     mstatus_in,
  input  logic [63:0]     hstatus_in,
  input  logic [XLEN-1:0] mepc_in,
  input  logic [XLEN-1:0] sepc_in,
  input  logic            pmp_no_rules,
  output logic            rsp_valid,
  output logic [2:0]      rsp_cause,
  output logic [63:0]     mstatus_out,
  output logic [63:0]     hstatus_out,
  output logic [1:0]      new_priv,
  output logic            new_virt,
  output logic [XLEN-1:0] ret_pc,
  output logic            swap_banks
);
  logic [XLEN-1:0] epc;
  ret_cause_e      cause;
  logic [SW-1:0]   mst_nxt, hst_nxt;
  logic [1:0]      priv_nxt;
  logic            virt_nxt, swap_nxt;

  assign epc = req_is_mret ? mepc_in : sepc_in;

  trap_ret_check #(.XLEN(XLEN), .HAS_C(HAS_C), .HAS_PMP(HAS_PMP)) u_check (
    .is_mret      (req_is_mret),
    .cur_priv     (cur_priv),
    .cur_virt     (cur_virt),
    .tsr          (mstatus_in[MS_TSR]),
    .vtsr         (hstatus_in[HS_VTSR]),
    .prev_mpp     (mstatus_in[MS_MPP_HI:MS_MPP_LO]),
    .epc_low      (epc[1:0]),
    .pmp_no_rules (pmp_no_rules),
    .cause        (cause)
  );

  trap_ret_update #(.HAS_H(HAS_H), .HAS_U(HAS_U), .SPEC_1_12(SPEC_1_12)) u_update (
    .is_mret  (req_is_mret),
    .cur_virt (cur_virt),
    .mst      (mstatus_in),
    .hst      (hstatus_in),
    .mst_nxt  (mst_nxt),
    .hst_nxt  (hst_nxt),
    .priv_nxt (priv_nxt),
    .virt_nxt (virt_nxt),
    .swap     (swap_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_cause   <= 3'd0;
      mstatus_out <= '0;
      hstatus_out <= '0;
      new_priv    <= 2'b00;
      new_virt    <= 1'b0;
      ret_pc      <= '0;
      swap_banks  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cause <= cause;
        ret_pc    <= epc;
        if (cause == CAUSE_NONE) begin
          mstatus_out <= mst_nxt;
          hstatus_out <= hst_nxt;
          new_priv    <= priv_nxt;
          new_virt    <= virt_nxt;
          swap_banks  <= swap_nxt;
        end else begin
          mstatus_out <= mstatus_in;
          hstatus_out <= hstatus_in;
          new_priv    <= cur_priv;
          new_virt    <= cur_virt;
          swap_banks  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/trap_return_checker.sv
module trap_return_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_is_mret,
  input logic [1:0]  cur_priv,
  input logic        rsp_valid,
  input logic [2:0]  rsp_cause,
  input logic [63:0] mstatus_out,
  input logic [1:0]  new_priv,
  input logic        new_virt,
  input logic        swap_banks
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r11_fault_holds_priv: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_cause == 3'd0 || (new_priv == $past(cur_priv) && !swap_banks)));
  a_r3_mret_below_m: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_mret && cur_priv != 2'b11) |=> (rsp_cause == 3'd1));
  a_r1_sret_from_u: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_mret && cur_priv == 2'b00) |=> (rsp_cause == 3'd1));
  a_r7_mret_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_mret) |=> (rsp_cause != 3'd0 || (mstatus_out[7] && !mstatus_out[39])));
  a_r6_sret_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_mret) |=> (rsp_cause != 3'd0 || (mstatus_out[5] && !mstatus_out[8])));
  a_r10_swap_implies_virt: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && swap_banks) |-> new_virt);
endmodule

bind trap_return_unit trap_return_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_is_mret (req_is_mret),
  .cur_priv    (cur_priv),
  .rsp_valid   (rsp_valid),
  .rsp_cause   (rsp_cause),
  .mstatus_out (mstatus_out),
  .new_priv    (new_priv),
  .new_virt    (new_virt),
  .swap_banks  (swap_banks)
);

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
  localparam int XLEN = 32;
  localparam int NV   = 16;

  typedef struct packed {
    logic            mret;
    logic [1:0]      priv;
    logic            virt;
    logic [63:0]     mst;
    logic [63:0]     hst;
    logic [XLEN-1:0] mepc;
    logic [XLEN-1:0] sepc;
    logic            pnr;
    logic [2:0]      ecause;
    logic [1:0]      epriv;
    logic            evirt;
    logic            eswap;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 64'h0,          64'h0,      32'h1000, 32'h2000, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0},
    '{1'b0, 2'd1, 1'b0, 64'h400000,     64'h0,      32'h1000, 32'h2000, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0},
    '{1'b0, 2'd3, 1'b0, 64'h420120,     64'h0,      32'h1000, 32'h2000, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0},
    '{1'b0, 2'd1, 1'b1, 64'h0,          64'h400000, 32'h1000, 32'h2000, 1'b0, 3'd2, 2'd1, 1'b1, 1'b0},
    '{1'b0, 2'd0, 1'b1, 64'h0,          64'h400000, 32'h1000, 32'h2000, 1'b0, 3'd1, 2'd0, 1'b1, 1'b0},
    '{1'b0, 2'd1, 1'b0, 64'h20,         64'h80,     32'h1000, 32'h2000, 1'b0, 3'd0, 2'd0, 1'b1, 1'b1},
    '{1'b0, 2'd1, 1'b1, 64'h100,        64'h80,     32'h1000, 32'h2000, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0},
    '{1'b0, 2'd1, 1'b0, 64'h0,          64'h0,      32'h1000, 32'h2002, 1'b0, 3'd3, 2'd1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 64'h0,          64'h0,      32'h1000, 32'h2001, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0},
    '{1'b1, 2'd1, 1'b0, 64'h0,          64'h0,      32'h1000, 32'h2000, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0},
    '{1'b1, 2'd3, 1'b0, 64'h20080,      64'h0,      32'h1000, 32'h2000, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0},
    '{1'b1, 2'd3, 1'b0, 64'h21800,      64'h0,      32'h1000, 32'h2000, 1'b1, 3'd0, 2'd3, 1'b0, 1'b0},
    '{1'b1, 2'd3, 1'b0, 64'h800,        64'h0,      32'h1000, 32'h2000, 1'b1, 3'd4, 2'd3, 1'b0, 1'b0},
    '{1'b1, 2'd3, 1'b0, 64'h800,        64'h0,      32'h1001, 32'h2000, 1'b1, 3'd3, 2'd3, 1'b0, 1'b0},
    '{1'b1, 2'd3, 1'b0, 64'h8000000800, 64'h0,      32'h1000, 32'h2000, 1'b0, 3'd0, 2'd1, 1'b1, 1'b1},
    '{1'b1, 2'd1, 1'b1, 64'h8000000800, 64'h0,      32'h1002, 32'h2000, 1'b1, 3'd1, 2'd1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_mret = 1'b0, cur_virt = 1'b0, pmp_no_rules = 1'b0;
  logic [1:0] cur_priv = 2'd0;
  logic [63:0] mstatus_in = '0, hstatus_in = '0;
  logic [XLEN-1:0] mepc_in = '0, sepc_in = '0;
  logic rsp_valid, new_virt, swap_banks;
  logic [2:0] rsp_cause;
  logic [63:0] mstatus_out, hstatus_out;
  logic [1:0] new_priv;
  logic [XLEN-1:0] ret_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN), .HAS_H(1'b1), .HAS_U(1'b1), .HAS_C(1'b0),
                     .HAS_PMP(1'b1), .SPEC_1_12(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mret(req_is_mret),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .mstatus_in(mstatus_in),
    .hstatus_in(hstatus_in), .mepc_in(mepc_in), .sepc_in(sepc_in),
    .pmp_no_rules(pmp_no_rules), .rsp_valid(rsp_valid), .rsp_cause(rsp_cause),
    .mstatus_out(mstatus_out), .hstatus_out(hstatus_out), .new_priv(new_priv),
    .new_virt(new_virt), .ret_pc(ret_pc), .swap_banks(swap_banks)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected mstatus from R6, R7, R8 (U mode present, 1.12 rules)
  function automatic logic [63:0] model_mst(input vec_t v);
    logic [63:0] m = v.mst;
    if (v.ecause != 3'd0) return m;
    if (v.mret) begin
      m[3] = v.mst[7]; m[7] = 1'b1; m[12:11] = 2'b00; m[39] = 1'b0;
      if (v.mst[12:11] != 2'b11) m[17] = 1'b0;
    end else begin
      m[1] = v.mst[5]; m[5] = 1'b1; m[8] = 1'b0; m[17] = 1'b0;
    end
    return m;
  endfunction

  // Expected hstatus from R9
  function automatic logic [63:0] model_hst(input vec_t v);
    logic [63:0] h = v.hst;
    if (v.ecause == 3'd0 && !v.mret && !v.virt) h[7] = 1'b0;
    return h;
  endfunction

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_is_mret = v.mret; cur_priv = v.priv; cur_virt = v.virt;
    mstatus_in = v.mst; hstatus_in = v.hst; mepc_in = v.mepc; sepc_in = v.sepc;
    pmp_no_rules = v.pnr;
  endtask

  task automatic check_vec(input vec_t v);
    chk("R11 valid", {63'd0, rsp_valid}, 64'd1);
    chk("R1/R2/R3/R4/R5 cause", {61'd0, rsp_cause}, {61'd0, v.ecause});
    chk("R6/R7 priv", {62'd0, new_priv}, {62'd0, v.epriv});
    chk("R9 virt", {63'd0, new_virt}, {63'd0, v.evirt});
    chk("R10 swap", {63'd0, swap_banks}, {63'd0, v.eswap});
    chk("R6/R7/R8 mstatus", mstatus_out, model_mst(v));
    chk("R9 hstatus", hstatus_out, model_hst(v));
    chk("R11 ret_pc", {32'd0, ret_pc}, {32'd0, (v.mret ? v.mepc : v.sepc)});
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs during reset
    chk("R12 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R12 mstatus_out", mstatus_out, 64'd0);
    chk("R12 ret_pc", {32'd0, ret_pc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle", {63'd0, rsp_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      req_valid = 1'b0;
      check_vec(VECS[i]);
      @(negedge clk);
      chk("R11 single beat", {63'd0, rsp_valid}, 64'd0);
    end

    // Back-to-back strobes: successful MRET then SRET fault (R11, R7, R1)
    drive(VECS[14]);
    @(negedge clk);
    check_vec(VECS[14]);
    drive(VECS[1]);
    @(negedge clk);
    req_valid = 1'b0;
    check_vec(VECS[1]);
    @(negedge clk);
    chk("R11 drop after burst", {63'd0, rsp_valid}, 64'd0);
    // Outputs hold while idle (R11)
    chk("R11 hold cause", {61'd0, rsp_cause}, 64'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule